// File: doc/BRIEF.md
# Two-Word Video Command Decoder

This block sits behind the control port of a video controller. Each 16-bit control write does one of two things. It may set one entry of a small internal register file. It may also carry half of a 32-bit access command. The block tracks whether the first half of a command is waiting for its second half. When a command is complete, it splits the command into an access-type code and a 16-bit address plus one extra upper address bit. These outputs tell the data-port logic which memory to touch and where.

The data port reports each access to the block through a single strobe. The block then advances the current address by the step held in register 15. A status-port read or a data-port access drops a half-finished command. The data access first decodes whatever command halves are stored. A control word whose low half has bit 7 set raises a one-cycle DMA request.

All outputs are registered. A control, data or status strobe sampled at a rising edge shows its effect on the outputs from that edge on.

Top module: `vid_cmd_decoder`

## Requirements
- R1: With no command half waiting, a control word whose bits 15:14 are 2'b10 is a register write. On the next edge, `reg_we` pulses for one cycle with `reg_idx` = bits 12:8 and `reg_val` = bits 7:0, and `acc_type` becomes 0.
- R2: With no half waiting, any other control word is stored as command bits 31:16, and a half becomes waiting. `acc_type`, `acc_addr` and `addr_ext` stay unchanged.
- R3: While a half is waiting, a control word is stored as command bits 15:0, the waiting state clears, and the full command is decoded onto the outputs on the next edge. If bit 7 of that word is 1, `dma_req` pulses for exactly one cycle.
- R4: `acc_type` = {4'b0, cmd[5:4], cmd[31:30]}. The codes are: 1 VRAM write, 3 CRAM write, 5 VSRAM write, 0 VRAM read, 8 CRAM read, 4 VSRAM read.
- R5: `acc_addr` = {cmd[1:0], cmd[29:16]}, and `addr_ext` = cmd[2].
- R6: When the decoded type is 1 (VRAM write), bit 7 of register 1 is ORed into bit 7 of `acc_type`, giving 0x81 in large-memory mode. No other type is affected.
- R7: A status read clears the waiting state, so the next 2'b10 word is a register write.
- R8: A data access while a half is waiting first decodes the stored upper half together with the last stored lower half. It then clears the waiting state and applies the R10 step to the decoded address.
- R9: A register write whose index is above 10 is ignored unless bit 2 of register 1 is 1. An index of 24 or more is always ignored. An ignored write gives no `reg_we` pulse and stores nothing, but it still clears `acc_type`.
- R10: Each data access adds register 15 to `acc_addr`, modulo 2^16. `addr_ext` is left unchanged.
- R11: Strobes arriving in the same cycle are handled in this order: a control write first, then a data access, then a status read. Only the first of these takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_data | input | 16 | Control-port write word |
| status_rd | input | 1 | Status-port read strobe |
| data_acc | input | 1 | Data-port access strobe (read or write) |
| reg_we | output | 1 | One-cycle register write pulse |
| reg_idx | output | 5 | Index of the register written |
| reg_val | output | 8 | Value written |
| acc_type | output | 8 | Decoded access-type code |
| acc_addr | output | 16 | Current access address |
| addr_ext | output | 1 | Extra upper address bit |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
Every result is one register away from its strobe. The register pulse, the DMA pulse, the decoded type and address, and the address step all become valid at the first rising edge that samples the strobe. The DMA pulse falls again at the following edge. Each bench task raises a strobe at a falling edge and drops it at the next falling edge, then samples the outputs there, one full edge after the capture. The DMA pulse is checked once more a cycle later to confirm it has gone low. Waiting state is not a port, so the bench observes it through the register pulse that the next 2'b10 word does or does not produce.

// File: rtl/vid_cmd_decoder.sv
module vid_cmd_decoder #(
  parameter int NUM_REGS  = 24,
  parameter int MODE_REG  = 1,
  parameter int STEP_REG  = 15,
  parameter int BASIC_MAX = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [15:0] ctrl_data,
  input  logic        status_rd,
  input  logic        data_acc,
  output logic        reg_we,
  output logic [4:0]  reg_idx,
  output logic [7:0]  reg_val,
  output logic [7:0]  acc_type,
  output logic [15:0] acc_addr,
  output logic        addr_ext,
  output logic        dma_req
);

  localparam int IDX_W = 5;

  logic [7:0]  regs [NUM_REGS];
  logic [31:0] cmd;
  logic        pending;

  logic [IDX_W-1:0] widx;
  logic             is_reg, idx_ok;
  logic [31:0]      cmd_eff;
  logic [7:0]       dec_type;
  logic [15:0]      dec_addr;
  logic [15:0]      step;

  assign widx    = ctrl_data[12:8];
  assign is_reg  = !pending && (ctrl_data[15:14] == 2'b10);
  assign idx_ok  = (32'(widx) < NUM_REGS) &&
                   ((32'(widx) <= BASIC_MAX) || regs[MODE_REG][2]);
  assign cmd_eff = (ctrl_wr && pending) ? {cmd[31:16], ctrl_data} : cmd;
  assign dec_addr = {cmd_eff[1:0], cmd_eff[29:16]};
  assign step    = {8'h00, regs[STEP_REG]};

  always_comb begin
    dec_type = {4'b0000, cmd_eff[5:4], cmd_eff[31:30]};
    if (dec_type == 8'h01 && regs[MODE_REG][7])
      dec_type[7] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'h00;
      cmd      <= '0;
      pending  <= 1'b0;
      reg_we   <= 1'b0;
      reg_idx  <= '0;
      reg_val  <= '0;
      acc_type <= '0;
      acc_addr <= '0;
      addr_ext <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      dma_req <= 1'b0;
      if (ctrl_wr) begin
        if (pending) begin
          cmd[15:0] <= ctrl_data;
          pending   <= 1'b0;
          acc_type  <= dec_type;
          acc_addr  <= dec_addr;
          addr_ext  <= cmd_eff[2];
          dma_req   <= ctrl_data[7];
        end else if (is_reg) begin
          acc_type <= 8'h00;
          if (idx_ok) begin
            regs[widx] <= ctrl_data[7:0];
            reg_we     <= 1'b1;
            reg_idx    <= widx;
            reg_val    <= ctrl_data[7:0];
          end
        end else begin
          cmd[31:16] <= ctrl_data;
          pending    <= 1'b1;
        end
      end else if (data_acc) begin
        pending <= 1'b0;
        if (pending) begin
          acc_type <= dec_type;
          addr_ext <= cmd_eff[2];
          acc_addr <= dec_addr + step;
        end else begin
          acc_addr <= acc_addr + step;
        end
      end else if (status_rd) begin
        pending <= 1'b0;
      end
    end
  end

  assert_reg_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(ctrl_wr) && !$past(pending) && $past(ctrl_data[15:14]) == 2'b10));

  assert_upper_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !pending && ctrl_data[15:14] != 2'b10) |=> (pending && $stable(acc_addr)));

  assert_dma_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ($past(ctrl_wr) && $past(pending) && $past(ctrl_data[7])));

  assert_dma_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req || $past(ctrl_wr));

  assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ctrl_wr && !data_acc) |=> !pending);

  assert_idx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (32'(reg_idx) < NUM_REGS));

  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ctrl_wr && !pending) |=>
      (acc_addr == 16'($past(acc_addr) + $past(step)) && $stable(addr_ext)));

endmodule

// File: tb/vid_cmd_decoder_test.sv
module vid_cmd_decoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctrl_wr = 0;
  logic [15:0] ctrl_data = 0;
  logic        status_rd = 0;
  logic        data_acc = 0;
  logic        reg_we, addr_ext, dma_req;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val, acc_type;
  logic [15:0] acc_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vid_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .status_rd(status_rd), .data_acc(data_acc), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_val(reg_val), .acc_type(acc_type),
    .acc_addr(acc_addr), .addr_ext(addr_ext), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctrl(input logic [15:0] d);
    @(negedge clk); ctrl_wr = 1; ctrl_data = d;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic dacc();
    @(negedge clk); data_acc = 1;
    @(negedge clk); data_acc = 0;
  endtask

  task automatic sts();
    @(negedge clk); status_rd = 1;
    @(negedge clk); status_rd = 0;
  endtask

  task automatic command(input logic [15:0] hi, input logic [15:0] lo);
    ctrl(hi);
    ctrl(lo);
  endtask

  task automatic t_reset();
    chk("reset R4 type", acc_type, 0);
    chk("reset R5 addr", acc_addr, 0);
    chk("reset R1 reg_we", reg_we, 0);
    chk("reset R3 dma", dma_req, 0);
  endtask

  task automatic t_gate_off();
    ctrl(16'h8F05);
    chk("R9 idx15 gated", reg_we, 0);
    command(16'h5234, 16'h0000);
    chk("R4 vram write type", acc_type, 8'h01);
    chk("R5 addr", acc_addr, 16'h1234);
    dacc();
    chk("R9 ignored step reg", acc_addr, 16'h1234);
  endtask

  task automatic t_regwrite();
    ctrl(16'h8104);
    chk("R1 pulse", reg_we, 1);
    chk("R1 idx", reg_idx, 1);
    chk("R1 val", reg_val, 8'h04);
    chk("R1 type cleared", acc_type, 0);
    ctrl(16'h8F02);
    chk("R9 idx15 allowed", reg_we, 1);
    chk("R9 idx15 idx", reg_idx, 15);
    chk("R9 idx15 val", reg_val, 8'h02);
  endtask

  task automatic t_step();
    command(16'h7FFF, 16'h0003);
    chk("R5 addr top", acc_addr, 16'hFFFF);
    dacc();
    chk("R10 wrap", acc_addr, 16'h0001);
    dacc();
    chk("R10 step", acc_addr, 16'h0003);
    chk("R10 ext kept", addr_ext, 0);
  endtask

  task automatic t_types();
    command(16'hC010, 16'h0002);
    chk("R4 cram write", acc_type, 8'h03);
    chk("R5 addr hi bits", acc_addr, 16'h8010);
    command(16'h4004, 16'h0014);
    chk("R4 vsram write", acc_type, 8'h05);
    chk("R5 ext bit", addr_ext, 1);
    chk("R5 addr", acc_addr, 16'h0004);
    command(16'h0000, 16'h0000);
    chk("R4 vram read", acc_type, 8'h00);
    command(16'h0000, 16'h0020);
    chk("R4 cram read", acc_type, 8'h08);
    command(16'h0000, 16'h0010);
    chk("R4 vsram read", acc_type, 8'h04);
  endtask

  task automatic t_big();
    ctrl(16'h8184);
    command(16'h5234, 16'h0000);
    chk("R6 big vram", acc_type, 8'h81);
    command(16'hC010, 16'h0002);
    chk("R6 cram unaffected", acc_type, 8'h03);
    ctrl(16'h8104);
  endtask

  task automatic t_dma();
    command(16'h4000, 16'h0080);
    chk("R3 dma pulse", dma_req, 1);
    chk("R3 type", acc_type, 8'h01);
    @(negedge clk);
    chk("R3 dma one cycle", dma_req, 0);
    ctrl(16'h8F02);
    chk("R3 pending cleared", reg_we, 1);
  endtask

  task automatic t_type_clear();
    command(16'h4004, 16'h0014);
    ctrl(16'h8F02);
    chk("R1 type cleared after reg", acc_type, 0);
  endtask

  task automatic t_status();
    ctrl(16'h5234);
    sts();
    ctrl(16'h8F04);
    chk("R7 status clears pending", reg_we, 1);
    chk("R7 val", reg_val, 8'h04);
    ctrl(16'h5234);
    ctrl(16'h8F04);
    chk("R3 lower not reg", reg_we, 0);
    chk("R3 type", acc_type, 8'h01);
    chk("R3 addr", acc_addr, 16'h1234);
    chk("R3 ext", addr_ext, 1);
    chk("R3 no dma", dma_req, 0);
  endtask

  task automatic t_data_pending();
    ctrl(16'h4100);
    chk("R2 addr held", acc_addr, 16'h1234);
    chk("R2 type held", acc_type, 8'h01);
    dacc();
    chk("R8 decode+step", acc_addr, 16'h0104);
    chk("R8 type", acc_type, 8'h01);
    chk("R8 ext from old lower", addr_ext, 1);
    ctrl(16'h8F02);
    chk("R8 pending cleared", reg_we, 1);
  endtask

  task automatic t_prec();
    @(negedge clk); ctrl_wr = 1; ctrl_data = 16'h8F06; data_acc = 1;
    @(negedge clk); ctrl_wr = 0; data_acc = 0;
    chk("R11 ctrl wins", reg_we, 1);
    chk("R11 addr untouched", acc_addr, 16'h0104);
    ctrl(16'h5234);
    @(negedge clk); data_acc = 1; status_rd = 1;
    @(negedge clk); data_acc = 0; status_rd = 0;
    chk("R11 data wins addr", acc_addr, 16'h123A);
    chk("R11 data wins ext", addr_ext, 1);
  endtask

  task automatic t_high_idx();
    ctrl(16'h9811);
    chk("R9 idx24 ignored", reg_we, 0);
    chk("R9 type still cleared", acc_type, 0);
    ctrl(16'h9F11);
    chk("R9 idx31 ignored", reg_we, 0);
    dacc();
    chk("R9 step untouched", acc_addr, 16'h1240);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gate_off();
    t_regwrite();
    t_step();
    t_types();
    t_big();
    t_dma();
    t_type_clear();
    t_status();
    t_data_pending();
    t_prec();
    t_high_idx();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule